// File: doc/BRIEF.md
# Universal Shift Register with Shared Data Bus

This block is an eight-bit storage register that, on each rising clock edge, keeps its contents, moves them one place toward either end, or captures a new word in parallel. The parallel input and the register's parallel output use the same bidirectional bus. For synthesis the bus is split into an input word, an output word and a drive enable. The pad or the parent level puts these together into a tri-state bus.

Two active-low enables control the bus driver. The driver also switches itself off whenever parallel load is selected, so the register can read external data from the bus it would otherwise drive. The two end stages are always available on dedicated serial outputs. Two or more instances can therefore be chained into a longer shifter by connecting each end output to the neighbour's matching serial input. An active-low asynchronous reset clears the register at once, whatever the clock or the mode is doing.

Top module: `usr_shift_reg`

## Requirements
- R1: When mode_sel is 2'b00, a rising clock edge leaves every register bit unchanged.
- R2: When mode_sel is 2'b01, a rising edge moves bit n into bit n+1 and ser_in_right into bit 0.
- R3: When mode_sel is 2'b10, a rising edge moves bit n into bit n-1 and ser_in_left into bit 7.
- R4: When mode_sel is 2'b11, a rising edge copies bus_in into the register.
- R5: rst_n low clears the register immediately, with no clock edge needed, and keeps it clear on any clock edge and in any mode while it stays low.
- R6: bus_oe is low whenever oe_a_n or oe_b_n is high.
- R7: bus_oe is low whenever mode_sel is 2'b11, whatever the enables are.
- R8: bus_oe is high when both enables are low and mode_sel is not 2'b11; bus_out always carries the register contents.
- R9: ser_out_lo equals register bit 0 and ser_out_hi equals bit 7 at all times, whatever the enable state.
- R10: Hold, shift, load and reset behave the same while bus_oe is low.
- R11: Two instances chained end to end (low instance ser_out_hi to high instance ser_in_right, high instance ser_out_lo to low instance ser_in_left) behave as one sixteen-bit shifter in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous clear, active low |
| mode_sel | input | 2 | 00 hold, 01 shift toward bit 7, 10 shift toward bit 0, 11 parallel load |
| ser_in_right | input | 1 | Serial bit entering bit 0 in mode 01 |
| ser_in_left | input | 1 | Serial bit entering bit 7 in mode 10 |
| oe_a_n | input | 1 | Bus drive enable, active low |
| oe_b_n | input | 1 | Second bus drive enable, active low |
| bus_in | input | 8 | Data read from the shared bus |
| bus_out | output | 8 | Register contents presented to the bus |
| bus_oe | output | 1 | Bus driver enable |
| ser_out_lo | output | 1 | Register bit 0 |
| ser_out_hi | output | 1 | Register bit 7 |

## Verification
Two chained instances are driven from one table. The table loads asymmetric words such as A5C3 and 1234, so any swapped or misrouted bit shows up in the sixteen-bit result. It then shifts in alternating ones and zeros in each direction, which separates the right and left paths and tests the crossing at the instance boundary. Some table rows raise one or both enables, or select load, during shifts and holds; this separates the gating of the bus driver from the register update. Directed tests then pull reset in the middle of a clock period and check the cleared state before the next edge and through a later edge.

// File: rtl/usr_pkg.sv
package usr_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_SHR  = 2'b01,
    MODE_SHL  = 2'b10,
    MODE_LOAD = 2'b11
  } usr_mode_e;

  // Next value of one stage given its own bit, both neighbours and the bus bit.
  function automatic logic pick_bit(
    input logic do_hold, input logic do_shr, input logic do_shl,
    input logic own, input logic from_lower, input logic from_upper,
    input logic par_bit);
    logic r;
    if (do_shr)       r = from_lower;
    else if (do_shl)  r = from_upper;
    else if (do_hold) r = own;
    else              r = par_bit;
    return r;
  endfunction

endpackage

// File: rtl/usr_mode_decode.sv
module usr_mode_decode
  import usr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode_sel,
  output logic       do_hold,
  output logic       do_shr,
  output logic       do_shl,
  output logic       do_load
);
  usr_mode_e mode;

  always_comb begin
    mode    = usr_mode_e'(mode_sel);
    do_hold = (mode == MODE_HOLD);
    do_shr  = (mode == MODE_SHR);
    do_shl  = (mode == MODE_SHL);
    do_load = (mode == MODE_LOAD);
  end

  assert_mode_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({do_hold, do_shr, do_shl, do_load}) == 1);

endmodule

// File: rtl/usr_stage_array.sv
module usr_stage_array
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             do_hold,
  input  logic             do_shr,
  input  logic             do_shl,
  input  logic             do_load,
  input  logic             sin_r,
  input  logic             sin_l,
  input  logic [WIDTH-1:0] par_in,
  output logic [WIDTH-1:0] q
);
  localparam int TOP = WIDTH - 1;

  logic [WIDTH-1:0] from_lower;
  logic [WIDTH-1:0] from_upper;
  logic [WIDTH-1:0] q_next;

  for (genvar n = 0; n < WIDTH; n++) begin : g_stage
    if (n == 0) begin : g_low_end
      assign from_lower[n] = sin_r;
    end else begin : g_low_mid
      assign from_lower[n] = q[n-1];
    end
    if (n == TOP) begin : g_high_end
      assign from_upper[n] = sin_l;
    end else begin : g_high_mid
      assign from_upper[n] = q[n+1];
    end
    assign q_next[n] = pick_bit(do_hold, do_shr, do_shl,
                                q[n], from_lower[n], from_upper[n], par_in[n]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_next;
  end

  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    do_hold |=> q == $past(q));
  assert_shift_right_R2: assert property (@(posedge clk) disable iff (!rst_n)
    do_shr |=> q == {$past(q[TOP-1:0]), $past(sin_r)});
  assert_shift_left_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_shl |=> q == {$past(sin_l), $past(q[TOP:1])});
  assert_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |=> q == $past(par_in));
  assert_reset_clear_R5: assert property (@(posedge clk)
    $rose(rst_n) |-> q == '0);

endmodule

// File: rtl/usr_bus_ctrl.sv
module usr_bus_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic oe_a_n,
  input  logic oe_b_n,
  input  logic do_load,
  output logic bus_oe
);
  logic en_pair_ok;

  assign en_pair_ok = ~(oe_a_n | oe_b_n);
  assign bus_oe     = en_pair_ok & ~do_load;

  assert_enable_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_a_n || oe_b_n) |-> !bus_oe);
  assert_load_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    do_load |-> !bus_oe);

endmodule

// File: rtl/usr_shift_reg.sv
module usr_shift_reg
  import usr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode_sel,
  input  logic             ser_in_right,
  input  logic             ser_in_left,
  input  logic             oe_a_n,
  input  logic             oe_b_n,
  input  logic [WIDTH-1:0] bus_in,
  output logic [WIDTH-1:0] bus_out,
  output logic             bus_oe,
  output logic             ser_out_lo,
  output logic             ser_out_hi
);
  localparam int TOP = WIDTH - 1;

  logic             do_hold, do_shr, do_shl, do_load;
  logic [WIDTH-1:0] q;

  usr_mode_decode u_decode (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
    .do_hold(do_hold), .do_shr(do_shr), .do_shl(do_shl), .do_load(do_load)
  );

  usr_stage_array #(.WIDTH(WIDTH)) u_stages (
    .clk(clk), .rst_n(rst_n),
    .do_hold(do_hold), .do_shr(do_shr), .do_shl(do_shl), .do_load(do_load),
    .sin_r(ser_in_right), .sin_l(ser_in_left), .par_in(bus_in), .q(q)
  );

  usr_bus_ctrl u_bus (
    .clk(clk), .rst_n(rst_n), .oe_a_n(oe_a_n), .oe_b_n(oe_b_n),
    .do_load(do_load), .bus_oe(bus_oe)
  );

  assign bus_out    = q;
  assign ser_out_lo = q[0];
  assign ser_out_hi = q[TOP];

  assert_bus_drive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe_a_n && !oe_b_n && mode_sel != 2'b11) |-> bus_oe);

endmodule

// File: tb/usr_shift_reg_bench.sv
module usr_shift_reg_bench;
  typedef struct packed {
    logic [1:0]  mode;
    logic        sr;
    logic        sl;
    logic        oea;
    logic        oeb;
    logic [15:0] din;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'hA5C3},
    '{2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 16'hFFFF},
    '{2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{2'b01, 1'b1, 1'b0, 1'b1, 1'b0, 16'h0000},
    '{2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 16'hFFFF},
    '{2'b10, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000},
    '{2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 16'h5555},
    '{2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 16'h1234},
    '{2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 16'h0000},
    '{2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 16'h8001},
    '{2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 16'h0000},
    '{2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 16'h0000}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       sr = 1'b0, sl = 1'b0, oea = 1'b1, oeb = 1'b1;
  logic [15:0] din = '0;
  logic [7:0] lo_out, hi_out;
  logic       lo_oe, hi_oe, lo_slo, lo_shi, hi_slo, hi_shi;
  int         n_run = 0, n_fail = 0;
  logic [15:0] model = '0;

  always #4 clk = ~clk;

  usr_shift_reg u_usr_shift_reg (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .ser_in_right(sr),
    .ser_in_left(hi_slo), .oe_a_n(oea), .oe_b_n(oeb), .bus_in(din[7:0]),
    .bus_out(lo_out), .bus_oe(lo_oe), .ser_out_lo(lo_slo), .ser_out_hi(lo_shi)
  );

  usr_shift_reg u_usr_shift_reg_hi (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode), .ser_in_right(lo_shi),
    .ser_in_left(sl), .oe_a_n(oea), .oe_b_n(oeb), .bus_in(din[15:8]),
    .bus_out(hi_out), .bus_oe(hi_oe), .ser_out_lo(hi_slo), .ser_out_hi(hi_shi)
  );

  task automatic chk(input logic ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_next(input logic [15:0] m, input vec_t v);
    case (v.mode)
      2'b01:   return {m[14:0], v.sr};
      2'b10:   return {v.sl, m[15:1]};
      2'b11:   return v.din;
      default: return m;
    endcase
  endfunction

  function automatic string mode_req(input logic [1:0] md, input logic off);
    string s;
    case (md)
      2'b00:   s = "R1 hold";
      2'b01:   s = "R2/R11 shift right";
      2'b10:   s = "R3/R11 shift left";
      default: s = "R4 load";
    endcase
    if (off) s = {s, " R10 bus off"};
    return s;
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic exp_oe;
    repeat (2) @(negedge clk);
    chk({hi_out, lo_out} == 16'h0, "R5 reset state", {hi_out, lo_out}, 16'h0);
    rst_n = 1'b1;
    foreach (VECS[i]) begin
      @(negedge clk);
      mode = VECS[i].mode; sr = VECS[i].sr; sl = VECS[i].sl;
      oea = VECS[i].oea; oeb = VECS[i].oeb; din = VECS[i].din;
      #1;
      exp_oe = !VECS[i].oea && !VECS[i].oeb && VECS[i].mode != 2'b11;
      chk(lo_oe == exp_oe && hi_oe == exp_oe, "R6/R7/R8 bus enable",
          {14'b0, hi_oe, lo_oe}, {14'b0, exp_oe, exp_oe});
      model = ref_next(model, VECS[i]);
      @(posedge clk);
      #2;
      chk({hi_out, lo_out} == model, mode_req(VECS[i].mode, !exp_oe),
          {hi_out, lo_out}, model);
      chk(lo_slo == model[0] && lo_shi == model[7] && hi_shi == model[15],
          "R9 serial outputs", {13'b0, hi_shi, lo_shi, lo_slo},
          {13'b0, model[15], model[7], model[0]});
    end

    // R5: reset in the middle of a period clears at once
    @(negedge clk);
    mode = 2'b11; din = 16'hBEEF; oea = 1'b0; oeb = 1'b0;
    @(posedge clk);
    #2;
    chk({hi_out, lo_out} == 16'hBEEF, "R4 load before reset", {hi_out, lo_out}, 16'hBEEF);
    mode = 2'b01; sr = 1'b1;
    #1 rst_n = 1'b0;
    #1;
    chk({hi_out, lo_out} == 16'h0, "R5 mid-cycle clear", {hi_out, lo_out}, 16'h0);
    chk(lo_slo == 1'b0 && hi_shi == 1'b0, "R9 serial after reset",
        {14'b0, hi_shi, lo_slo}, 16'h0);
    @(posedge clk);
    #2;
    chk({hi_out, lo_out} == 16'h0, "R5 reset overrides clock and mode",
        {hi_out, lo_out}, 16'h0);
    @(negedge clk);
    rst_n = 1'b1;
    mode = 2'b10; sl = 1'b1; oea = 1'b1;
    @(posedge clk);
    #2;
    chk({hi_out, lo_out} == 16'h8000, "R3/R10 shift left after reset bus off",
        {hi_out, lo_out}, 16'h8000);
    chk(hi_shi == 1'b1 && lo_oe == 1'b0, "R9/R6 serial out with bus off",
        {14'b0, hi_shi, lo_oe}, 16'h2);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule